// File: doc/BRIEF.md
# Program Exception Cause Unit

This block sits at the instruction issue point. It looks at each decoded instruction and decides whether that instruction must raise a program interrupt. The possible reasons are an opcode that is not recognised, a privileged opcode issued in user mode, a trap whose compare condition is met, a floating-point or coprocessor opcode for a unit that is not fitted, and a floating-point or coprocessor opcode while that unit's interrupt enable is set.

When an interrupt is raised, the block does four things. In the same cycle it tells the pipeline not to execute the instruction. On the next clock edge it writes a one-hot cause into its syndrome register, saves the instruction address into save/restore register 0 and sends out a single-cycle interrupt request. The handler address is always the upper half of the vector prefix followed by the offset 0x0600. A strap input marks whether memory management is present. When the strap is low, TLB maintenance opcodes are treated as unrecognised. No enable can mask a program interrupt.

Top module: `prog_fault_unit`

## Requirements
- R1: A synchronous reset clears the syndrome register, save/restore register 0 and the interrupt request.
- R2: An issued instruction flagged unrecognised raises the interrupt with syndrome bit 5 (illegal).
- R3: A TLB opcode raises the illegal cause (bit 5) when the memory-management strap is 0. When the strap is 1 and no other flag is set, it raises nothing.
- R4: A privileged opcode raises syndrome bit 4 (privileged) when user mode is 1. It raises nothing when user mode is 0.
- R5: A floating-point or coprocessor opcode whose unit is not present raises syndrome bit 3 (unimplemented), whatever the unit's enable is.
- R6: A floating-point opcode raises bit 2 when the unit is present and its enable is set. A coprocessor opcode raises bit 1 under the same conditions. With the enable clear, neither raises anything.
- R7: A trap opcode raises bit 0 only when the trap-condition input is 1.
- R8: When several causes hold at once, only one is recorded, by priority: illegal, then privileged, then unimplemented, then floating-point, then coprocessor, then trap.
- R9: A taken interrupt leaves exactly one syndrome bit set and clears the rest. Without a taken interrupt, the syndrome register holds its value.
- R10: The execution-block output is high in the same cycle as an issued instruction that raises an interrupt, and low otherwise.
- R11: On the clock edge after detection, the interrupt request is high for exactly one cycle and save/restore register 0 holds the instruction's address.
- R12: The vector output equals the prefix input followed by 16'h0600.
- R13: With issue valid low, no flag has any effect on the outputs or the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | An instruction is at issue this cycle |
| inst_addr | input | 32 | Address of the issuing instruction |
| user_mode | input | 1 | 1 = user (problem) state |
| op_illegal | input | 1 | Opcode not recognised |
| op_priv | input | 1 | Opcode is privileged |
| op_tlb | input | 1 | Opcode is a TLB maintenance opcode |
| op_trap | input | 1 | Opcode is a trap |
| trap_hit | input | 1 | Trap compare condition met |
| op_fpu | input | 1 | Opcode is floating-point |
| op_apu | input | 1 | Opcode is coprocessor |
| fpu_present | input | 1 | Floating-point unit fitted |
| apu_present | input | 1 | Coprocessor fitted |
| fpu_irq_en | input | 1 | Floating-point interrupt enable |
| apu_irq_en | input | 1 | Coprocessor interrupt enable |
| mmu_present | input | 1 | Memory-management strap |
| vec_prefix | input | 16 | Upper half of the handler vector |
| block_exec | output | 1 | Do not execute the issuing instruction |
| irq_req | output | 1 | Single-cycle interrupt request |
| syndrome | output | 6 | One-hot program cause register |
| srr0 | output | 32 | Saved faulting instruction address |
| vector | output | 32 | Handler address |

## Verification
The hardest case to reach from the ports is an instruction that meets several causes at once. Only the winning cause may appear in the syndrome, and it must replace a different cause left over from the previous instruction. The stimulus first records one cause. It then issues instructions that stack two or more flags, for example a privileged TLB opcode in user mode with the strap low, or a trap with its condition met on an absent floating-point unit. This exercises each step of the priority chain and the clearing of the stale bit.

// File: rtl/prog_fault_unit.sv
module prog_fault_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_valid,
  input  logic [AW-1:0] inst_addr,
  input  logic          user_mode,
  input  logic          op_illegal,
  input  logic          op_priv,
  input  logic          op_tlb,
  input  logic          op_trap,
  input  logic          trap_hit,
  input  logic          op_fpu,
  input  logic          op_apu,
  input  logic          fpu_present,
  input  logic          apu_present,
  input  logic          fpu_irq_en,
  input  logic          apu_irq_en,
  input  logic          mmu_present,
  input  logic [15:0]   vec_prefix,
  output logic          block_exec,
  output logic          irq_req,
  output logic [5:0]    syndrome,
  output logic [AW-1:0] srr0,
  output logic [AW-1:0] vector
);
  localparam int B_TRAP = 0, B_APU = 1, B_FPU = 2, B_UNIMP = 3, B_PRIV = 4, B_ILL = 5;
  localparam logic [15:0] VEC_OFS = 16'h0600;

  logic is_ill, is_priv, is_unimp, is_fpu, is_apu, is_trap;
  logic [5:0] cause;

  assign is_ill   = op_illegal | (op_tlb & ~mmu_present);
  assign is_priv  = op_priv & user_mode;
  assign is_unimp = (op_fpu & ~fpu_present) | (op_apu & ~apu_present);
  assign is_fpu   = op_fpu & fpu_present & fpu_irq_en;
  assign is_apu   = op_apu & apu_present & apu_irq_en;
  assign is_trap  = op_trap & trap_hit;

  always_comb begin
    cause = '0;
    if (is_ill)        cause[B_ILL]   = 1'b1;
    else if (is_priv)  cause[B_PRIV]  = 1'b1;
    else if (is_unimp) cause[B_UNIMP] = 1'b1;
    else if (is_fpu)   cause[B_FPU]   = 1'b1;
    else if (is_apu)   cause[B_APU]   = 1'b1;
    else if (is_trap)  cause[B_TRAP]  = 1'b1;
  end

  assign block_exec = issue_valid & (|cause);
  assign vector     = {{(AW-32){1'b0}}, vec_prefix, VEC_OFS};

  always_ff @(posedge clk) begin
    if (rst) begin
      syndrome <= '0;
      srr0     <= '0;
      irq_req  <= 1'b0;
    end else begin
      irq_req <= block_exec;
      if (block_exec) begin
        syndrome <= cause;
        srr0     <= inst_addr;
      end
    end
  end
endmodule

module prog_fault_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          issue_valid,
  input logic [AW-1:0] inst_addr,
  input logic          op_illegal,
  input logic          block_exec,
  input logic          irq_req,
  input logic [5:0]    syndrome,
  input logic [AW-1:0] srr0
);
  // R9
  onehot_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $countones(syndrome) == 1);
  // R9
  hold_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !block_exec |=> $stable(syndrome));
  // R11
  pulse_follows_chk: assert property (@(posedge clk) disable iff (rst)
    block_exec |=> irq_req);
  // R11
  no_spurious_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !block_exec |=> !irq_req);
  // R11
  srr0_capture_chk: assert property (@(posedge clk) disable iff (rst)
    block_exec |=> srr0 == $past(inst_addr));
  // R2
  illegal_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && op_illegal) |=> syndrome[5]);
  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |-> !block_exec);
endmodule

bind prog_fault_unit prog_fault_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .issue_valid(issue_valid), .inst_addr(inst_addr),
  .op_illegal(op_illegal), .block_exec(block_exec), .irq_req(irq_req),
  .syndrome(syndrome), .srr0(srr0)
);

// File: tb/prog_fault_unit_test.sv
module prog_fault_unit_test;
  logic clk = 0, rst = 1;
  logic issue_valid = 0;
  logic [31:0] inst_addr = '0;
  logic user_mode = 0, op_illegal = 0, op_priv = 0, op_tlb = 0, op_trap = 0, trap_hit = 0;
  logic op_fpu = 0, op_apu = 0, fpu_present = 1, apu_present = 1;
  logic fpu_irq_en = 0, apu_irq_en = 0, mmu_present = 1;
  logic [15:0] vec_prefix = 16'hFFF0;
  logic block_exec, irq_req;
  logic [5:0] syndrome;
  logic [31:0] srr0, vector;

  int errors = 0, checks = 0;
  logic [5:0] last_cause = '0;

  always #4 clk = ~clk;

  prog_fault_unit uut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    issue_valid = 0; op_illegal = 0; op_priv = 0; op_tlb = 0; op_trap = 0;
    trap_hit = 0; op_fpu = 0; op_apu = 0; user_mode = 0;
  endtask

  // Flags packed: {ill, priv, tlb, trap, hit, fpu, apu, user}; exp = expected one-hot or 0
  task automatic issue(string req, logic [7:0] f, logic [5:0] exp, logic [31:0] pc);
    @(negedge clk);
    {op_illegal, op_priv, op_tlb, op_trap, trap_hit, op_fpu, op_apu, user_mode} = f;
    inst_addr = pc; issue_valid = 1;
    #1 check({req, " R10 block"}, block_exec, exp != 0);
    @(negedge clk);
    clear_flags();
    check({req, " R11 pulse"}, irq_req, exp != 0);
    if (exp != 0) begin
      last_cause = exp;
      check({req, " R11 srr0"}, srr0, pc);
    end
    check({req, " R9 syndrome"}, syndrome, last_cause);
    @(negedge clk);
    check({req, " R11 pulse drop"}, irq_req, 0);
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    check("R1 syndrome", syndrome, 0);
    check("R1 srr0", srr0, 0);
    check("R1 irq", irq_req, 0);
    check("R12 vector", vector, 32'hFFF0_0600);
    vec_prefix = 16'h1234;
    #1 check("R12 vector", vector, 32'h1234_0600);
    rst = 0;
  endtask

  task automatic t_basic();
    issue("R2 illegal", 8'b1000_0000, 6'b100000, 32'h100);
    mmu_present = 0;
    issue("R3 tlb no mmu", 8'b0010_0000, 6'b100000, 32'h104);
    mmu_present = 1;
    issue("R3 tlb with mmu", 8'b0010_0000, 6'b000000, 32'h108);
    issue("R4 priv user", 8'b0100_0001, 6'b010000, 32'h10C);
    issue("R4 priv super", 8'b0100_0000, 6'b000000, 32'h110);
  endtask

  task automatic t_units();
    fpu_present = 0; fpu_irq_en = 0;
    issue("R5 fpu absent", 8'b0000_0100, 6'b001000, 32'h200);
    fpu_present = 1; apu_present = 0; apu_irq_en = 1;
    issue("R5 apu absent", 8'b0000_0010, 6'b001000, 32'h204);
    apu_present = 1; apu_irq_en = 0;
    issue("R6 apu en off", 8'b0000_0010, 6'b000000, 32'h208);
    fpu_irq_en = 1;
    issue("R6 fpu en", 8'b0000_0100, 6'b000100, 32'h20C);
    apu_irq_en = 1;
    issue("R6 apu en", 8'b0000_0010, 6'b000010, 32'h210);
    fpu_irq_en = 0; apu_irq_en = 0;
  endtask

  task automatic t_trap();
    issue("R7 trap hit", 8'b0001_1000, 6'b000001, 32'h300);
    issue("R7 trap miss", 8'b0001_0000, 6'b000000, 32'h304);
  endtask

  task automatic t_priority();
    mmu_present = 0;
    issue("R8 ill over priv", 8'b0110_0001, 6'b100000, 32'h400);
    mmu_present = 1; fpu_present = 0;
    issue("R8 priv over unimp", 8'b0100_0101, 6'b010000, 32'h404);
    issue("R8 unimp over trap", 8'b0001_1100, 6'b001000, 32'h408);
    fpu_present = 1; fpu_irq_en = 1; apu_irq_en = 1;
    issue("R8 fpu over apu", 8'b0000_0110, 6'b000100, 32'h40C);
    issue("R8 apu over trap", 8'b0001_1010, 6'b000010, 32'h410);
    fpu_irq_en = 0; apu_irq_en = 0;
  endtask

  task automatic t_idle();
    @(negedge clk);
    {op_illegal, op_priv, op_trap, trap_hit, user_mode} = 5'b11111;
    inst_addr = 32'hDEAD; issue_valid = 0;
    #1 check("R13 block", block_exec, 0);
    @(negedge clk);
    check("R13 pulse", irq_req, 0);
    check("R13 syndrome", syndrome, last_cause);
    check("R13 srr0", srr0, 32'h410);
    clear_flags();
  endtask

  initial begin
    t_reset();
    t_basic();
    t_units();
    t_trap();
    t_priority();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule